// File: doc/BRIEF.md
# Clock Loss Monitor with Reset Request

This block watches a system clock from a free-running reference clock and asks for a chip reset when that clock slows down too far or stops. Rising edges of the watched clock pass through a synchronizer into the reference domain. A counter measures the gap in reference cycles since the last edge. A gap that closes late counts as a slow clock and gives a reset pulse of fixed length. A gap that never closes counts as an absent clock, and the reset request is then held low until edges come back.

Software turns the monitor on with a single enable bit. Whenever the monitor starts a reset request it sets a cause flag. That flag survives the reset it caused, so the restarted software can see where the reset came from. A read-to-clear strobe or power-on reset clears it. The reset request is active low and is meant to drive an open-drain reset line outside this block. Everything runs on the reference clock. The watched clock is only sampled.

The enable must stay off when the watched clock runs so slowly that its normal period is longer than the absence limit. Such a clock would look absent.

Top module: `clkmon_top`

## Requirements
- R1: A cycle with `cfg_wr` high loads `cfg_wdata` into the enable bit, and the bit shows on `enable_o` after the next reference edge. 1 means enabled and 0 means disabled. The bit keeps its value in every cycle without a write.
- R2: While `enable_o` is 0, `rst_req_n` never falls and `cause_flag` is never set, whatever `mon_clk` does.
- R3: While enabled, a watched clock whose period is no longer than SLOW_LIMIT reference cycles never pulls `rst_req_n` low.
- R4: While enabled, a rising edge arriving SLOW_LIMIT+1 or more reference cycles after the previous one, but before the absence limit is reached, pulls `rst_req_n` low for exactly PULSE_LEN reference cycles. The default PULSE_LEN is 4.
- R5: While enabled, if no rising edge is seen for ABSENT_LIMIT reference cycles after the last one, `rst_req_n` goes low. It stays low until a synchronized rising edge returns, and goes high on the cycle after that edge is detected.
- R6: `cause_flag` rises in the same cycle that `rst_req_n` falls. After that it stays high until a cycle with `flag_clr` high. When a set and a clear fall in the same cycle, the set wins.
- R7: A slow edge that arrives while a reset pulse is already running neither restarts nor lengthens that pulse. An absence still present when the pulse ends starts a held reset.
- R8: While `por_n` is low, and for two reference cycles after it rises, `rst_req_n` is 1, `cause_flag` is 0 and `enable_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all state runs on it |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mon_clk | input | 1 | Watched clock, sampled as data |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_wdata | input | 1 | Value written to the enable bit |
| flag_clr | input | 1 | Read-to-clear strobe for the cause flag |
| rst_req_n | output | 1 | Reset request, active low |
| cause_flag | output | 1 | Set when the monitor starts a reset request |
| enable_o | output | 1 | Current value of the enable bit |

## Verification
The cause flag can be set by a new reset request and cleared by the read strobe in the same reference cycle. The set must win, or software would lose the cause of the reset. The bench holds `flag_clr` high for the whole of a slow-clock interval. It then checks that the flag is still seen high on the cycle the pulse begins, and low on the cycle after. Random stimulus also asserts the strobe at random times. A cycle-by-cycle bench model compares the flag on every cycle, so collisions with a slow edge or with the absence limit are judged the same way.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Reset sequencer states
  typedef enum logic [1:0] {
    CM_IDLE  = 2'd0,
    CM_PULSE = 2'd1,
    CM_HOLD  = 2'd2
  } cm_state_e;

endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d[0] = async_in;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_comb pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/clkmon_gap_timer.sv
module clkmon_gap_timer #(
  parameter int SLOW_LIMIT   = 12,
  parameter int ABSENT_LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rise,
  output logic slow_evt,
  output logic absent
);

  localparam int GW = $clog2(ABSENT_LIMIT + 1);
  localparam logic [GW-1:0] ABS_C  = GW'(ABSENT_LIMIT);
  localparam logic [GW-1:0] SLOW_C = GW'(SLOW_LIMIT);

  logic [GW-1:0] gap_q;
  logic [GW-1:0] gap_d;
  logic          gap_ce;
  logic          at_limit;

  assign at_limit = (gap_q == ABS_C);

  // Count only while enabled, restart on each edge, saturate at the limit
  always_comb begin
    gap_ce = 1'b0;
    gap_d  = gap_q;
    if (!enable || rise) begin
      gap_ce = 1'b1;
      gap_d  = '0;
    end else if (!at_limit) begin
      gap_ce = 1'b1;
      gap_d  = gap_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_ce) gap_q <= gap_d;
  end

  assign slow_evt = enable & rise & (gap_q >= SLOW_C);
  assign absent   = enable & ~rise & at_limit;

endmodule

// File: rtl/clkmon_reset_fsm.sv
module clkmon_reset_fsm
  import clkmon_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_evt,
  input  logic absent,
  input  logic rise,
  input  logic flag_clr,
  output logic req_n,
  output logic hold,
  output logic cause
);

  localparam int PW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PW-1:0] LAST_C = PW'(PULSE_LEN - 1);

  cm_state_e     st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic          cause_q, cause_d;
  logic          start;

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    start = 1'b0;
    unique case (st_q)
      CM_IDLE: begin
        if (absent) begin
          st_d  = CM_HOLD;
          start = 1'b1;
        end else if (slow_evt) begin
          st_d  = CM_PULSE;
          pc_d  = '0;
          start = 1'b1;
        end
      end
      CM_PULSE: begin
        if (pc_q == LAST_C) st_d = CM_IDLE;
        else                pc_d = pc_q + PW'(1);
      end
      CM_HOLD: begin
        if (rise) st_d = CM_IDLE;
      end
      default: st_d = CM_IDLE;
    endcase
  end

  // Set has priority over the read-to-clear strobe
  always_comb begin
    cause_d = cause_q;
    if (start)         cause_d = 1'b1;
    else if (flag_clr) cause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CM_IDLE;
      pc_q    <= '0;
      cause_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      cause_q <= cause_d;
    end
  end

  assign req_n = (st_q == CM_IDLE);
  assign hold  = (st_q == CM_HOLD);
  assign cause = cause_q;

endmodule

// File: rtl/clkmon_top.sv
module clkmon_top #(
  parameter int SYNC_STAGES  = 2,
  parameter int SLOW_LIMIT   = 12,
  parameter int ABSENT_LIMIT = 40,
  parameter int PULSE_LEN    = 4
) (
  input  logic ref_clk,
  input  logic por_n,
  input  logic mon_clk,
  input  logic cfg_wr,
  input  logic cfg_wdata,
  input  logic flag_clr,
  output logic rst_req_n,
  output logic cause_flag,
  output logic enable_o
);

  logic rst_n;
  logic en_q, en_d;
  logic mon_rise;
  logic slow_evt;
  logic absent;
  logic hold_q;

  clkmon_rst_sync #(.STAGES(2)) u_rst (
    .clk    (ref_clk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  always_comb begin
    en_d = cfg_wr ? cfg_wdata : en_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .async_in (mon_clk),
    .rise     (mon_rise)
  );

  clkmon_gap_timer #(
    .SLOW_LIMIT   (SLOW_LIMIT),
    .ABSENT_LIMIT (ABSENT_LIMIT)
  ) u_gap (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .enable   (en_q),
    .rise     (mon_rise),
    .slow_evt (slow_evt),
    .absent   (absent)
  );

  clkmon_reset_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .slow_evt (slow_evt),
    .absent   (absent),
    .rise     (mon_rise),
    .flag_clr (flag_clr),
    .req_n    (rst_req_n),
    .hold     (hold_q),
    .cause    (cause_flag)
  );

  assign enable_o = en_q;

endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
  parameter int PULSE_LEN = 4
) (
  input logic ref_clk,
  input logic rst_n,
  input logic cfg_wr,
  input logic cfg_wdata,
  input logic flag_clr,
  input logic rst_req_n,
  input logic cause_flag,
  input logic enable_o,
  input logic hold
);

  logic [7:0] low_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (rst_req_n)   low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
  end

  p_enable_write_r1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_wr |=> (enable_o == $past(cfg_wdata)));

  p_disabled_quiet_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!enable_o && rst_req_n) |=> rst_req_n);

  p_pulse_bound_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!rst_req_n && low_cnt >= 8'(PULSE_LEN)) |-> hold);

  p_flag_on_request_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(rst_req_n) |-> cause_flag);

  p_flag_sticky_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cause_flag && !flag_clr) |=> cause_flag);

endmodule

bind clkmon_top clkmon_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .flag_clr   (flag_clr),
  .rst_req_n  (rst_req_n),
  .cause_flag (cause_flag),
  .enable_o   (enable_o),
  .hold       (hold_q)
);

// File: tb/clkmon_top_test.sv
module clkmon_top_test;

  localparam int SLOW  = 12;
  localparam int ABS   = 40;
  localparam int PLEN  = 4;

  logic ref_clk = 1'b0;
  logic por_n, mon_clk, cfg_wr, cfg_wdata, flag_clr;
  logic rst_req_n, cause_flag, enable_o;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #10 ref_clk = ~ref_clk;  // 50 MHz

  clkmon_top #(.SLOW_LIMIT(SLOW), .ABSENT_LIMIT(ABS), .PULSE_LEN(PLEN)) uut (
    .ref_clk(ref_clk), .por_n(por_n), .mon_clk(mon_clk), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .rst_req_n(rst_req_n),
    .cause_flag(cause_flag), .enable_o(enable_o)
  );

  // Bench model of the requirements, stepped once per reference edge
  logic m_r1, m_r2, m_s1, m_s2, m_s3, m_en, m_flag;
  int   m_gap, m_st, m_pc;   // m_st: 0 idle, 1 pulse, 2 hold

  // Watched clock generator: period in reference cycles, 0 = stopped
  int mon_per = 0;
  int mon_ph  = 0;

  // Observed low-run tracking
  int run = 0, last_run = 0, low_seen = 0, flag_seen = 0;

  task automatic m_reset();
    m_r1 = 0; m_r2 = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    m_en = 0; m_flag = 0; m_gap = 0; m_st = 0; m_pc = 0;
  endtask

  task automatic m_step();
    logic edg, absn, slw, start;
    if (!por_n) begin
      m_reset();
      return;
    end
    if (m_r2) begin
      edg   = m_s2 & ~m_s3;
      absn  = m_en && (m_gap == ABS) && !edg;
      slw   = m_en && edg && (m_gap >= SLOW);
      start = 0;
      case (m_st)
        0: if (absn) begin m_st = 2; start = 1; end
           else if (slw) begin m_st = 1; m_pc = 0; start = 1; end
        1: if (m_pc == PLEN - 1) m_st = 0; else m_pc++;
        default: if (edg) m_st = 0;
      endcase
      if (!m_en || edg) m_gap = 0;
      else if (m_gap != ABS) m_gap++;
      if (start) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (cfg_wr) m_en = cfg_wdata;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = mon_clk;
    end
    m_r2 = m_r1; m_r1 = 1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare all outputs against the model (called at a falling edge)
  task automatic compare();
    string rq;
    rq = (m_st == 2) ? "R5" : (m_st == 1) ? "R4" : "R3";
    chk(rst_req_n == (m_st == 0), rq, "rst_req_n", rst_req_n, m_st == 0);
    chk(cause_flag == m_flag, "R6", "cause_flag", cause_flag, m_flag);
    chk(enable_o == m_en, "R1", "enable_o", enable_o, m_en);
    if (!rst_req_n) begin run++; low_seen++; end
    else if (run > 0) begin last_run = run; run = 0; end
    if (cause_flag) flag_seen++;
  endtask

  // One reference cycle: drive at falling edge, model the rising edge, check
  task automatic tick();
    if (mon_per > 0) begin
      mon_ph  = (mon_ph + 1) % mon_per;
      mon_clk = (mon_ph < mon_per / 2);
    end
    m_step();
    @(negedge ref_clk);
    cycles++;
    compare();
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) tick();
    cfg_wr = 0; flag_clr = 0;
  endtask

  task automatic write_en(input logic v);
    cfg_wr = 1; cfg_wdata = v;
    tick();
    cfg_wr = 0;
  endtask

  initial begin
    por_n = 0; mon_clk = 0; cfg_wr = 0; cfg_wdata = 0; flag_clr = 0;
    m_reset();
    repeat (3) @(negedge ref_clk);
    // R8: reset values while por_n is low
    chk(rst_req_n == 1, "R8", "rst_req_n in reset", rst_req_n, 1);
    chk(cause_flag == 0, "R8", "cause_flag in reset", cause_flag, 0);
    chk(enable_o == 0, "R8", "enable_o in reset", enable_o, 0);
    por_n = 1;
    run_n(2);
    chk(enable_o == 0 && rst_req_n == 1, "R8", "outputs after release",
        {enable_o, rst_req_n}, 1);

    // R2: disabled, watched clock stopped, then slow
    low_seen = 0; mon_per = 0;
    run_n(100);
    mon_per = 30; run_n(120);
    chk(low_seen == 0, "R2", "lows while disabled", low_seen, 0);
    chk(cause_flag == 0, "R2", "flag while disabled", cause_flag, 0);

    // R1: enable write
    write_en(1);
    chk(enable_o == 1, "R1", "enable after write", enable_o, 1);

    // R3: fast watched clock
    mon_per = 8; run_n(30);
    low_seen = 0; run_n(300);
    chk(low_seen == 0, "R3", "lows with fast clock", low_seen, 0);
    mon_per = SLOW; low_seen = 0; run_n(200);
    chk(low_seen == 0, "R3", "lows at the slow limit", low_seen, 0);

    // R4: slow watched clock
    mon_per = 20; run_n(90);
    chk(last_run == PLEN, "R4", "slow pulse length", last_run, PLEN);
    chk(cause_flag == 1, "R4", "flag after slow pulse", cause_flag, 1);

    // R6: read-to-clear
    mon_per = 8; run_n(20);
    flag_clr = 1; tick(); flag_clr = 0;
    chk(cause_flag == 0, "R6", "flag after clear", cause_flag, 0);

    // R6: clear held across slow events (set beats clear)
    mon_per = 25; flag_seen = 0; flag_clr = 1;
    for (int i = 0; i < 80; i++) tick();
    flag_clr = 0;
    chk(flag_seen > 0, "R6", "set wins over clear", flag_seen, 1);

    // R5: absent clock holds reset, released by returning edges
    mon_per = 0; mon_clk = 0; run_n(ABS + 20);
    chk(rst_req_n == 0, "R5", "held while absent", rst_req_n, 0);
    run_n(100);
    chk(rst_req_n == 0, "R5", "still held", rst_req_n, 0);
    mon_per = 8; run_n(20);
    chk(rst_req_n == 1, "R5", "released after edges", rst_req_n, 1);

    // R7: pulse followed by absence
    mon_per = 20; run_n(25);
    mon_per = 0; mon_clk = 0; run_n(ABS + 10);
    chk(rst_req_n == 0, "R7", "absence after pulse", rst_req_n, 0);
    mon_per = 6; run_n(20);

    // Random mix, fixed seed
    void'($urandom(32'h5eed_c10c));
    for (int blk = 0; blk < 120; blk++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4)      mon_per = $urandom_range(2, SLOW);
      else if (sel < 8) mon_per = $urandom_range(SLOW + 1, ABS + 6);
      else              mon_per = 0;
      for (int i = 0; i < $urandom_range(40, 300); i++) begin
        cfg_wr    = ($urandom_range(0, 60) == 0);
        cfg_wdata = ($urandom_range(0, 4) != 0);
        flag_clr  = ($urandom_range(0, 5) == 0);
        if ($urandom_range(0, 2000) == 0) por_n = 0;
        else if (!por_n && $urandom_range(0, 2) == 0) por_n = 1;
        tick();
      end
      por_n = 1;
      if (!enable_o && $urandom_range(0, 1) == 1) write_en(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(20 * 190000);
    fails++;
    vectors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule